// File: doc/BRIEF.md
# Capture Input Noise Filter

This block conditions one asynchronous capture pin before edge detection. The raw pin first passes through a chain of flip-flops on the system clock. The synchronized level is then sampled on a sampling enable, and a filtered level is kept. The filtered level takes a new value only after three samples in a row agree on that value. A shorter pulse is treated as noise and is dropped.

The sampling enable comes from one of four sources, selected by a 2-bit rate code: every system clock, every 8th clock, every 32nd clock, or an external count-source tick. A filter enable picks either the filtered level or the synchronized, unfiltered level. The chosen level drives a rising-edge pulse and a falling-edge pulse for a downstream capture unit. It is also brought out as a level output.

Top module: `cap_filt_top`

## Requirements
- R1: The raw pin passes through two system-clock flip-flops. With the filter disabled, a pin change shows on `lvl_o` after the second rising clock edge that follows it.
- R2: With the filter enabled, `lvl_o` takes a new value only on a sampling enable at which the last three samples, the current one included, all equal that value. A pulse that spans fewer than three samples leaves `lvl_o` unchanged.
- R3: `rate_sel` sets the sampling enable. Code 2'b00 samples on every clock. Code 2'b01 samples when the free-running counter's low three bits are 7, which is every 8th clock. Code 2'b10 samples when the 5-bit counter is 31, which is every 32nd clock. Code 2'b11 samples on each clock where `ext_tick` is high.
- R4: When `filt_en` is 1, `lvl_o` is the filtered level. When `filt_en` is 0, `lvl_o` is the synchronized, unfiltered pin.
- R5: `rise_o` is high for exactly one clock when `lvl_o` goes from 0 to 1. `fall_o` is high for exactly one clock when `lvl_o` goes from 1 to 0. The two pulses are never high together.
- R6: While reset (`rst_n` low) is asserted, and right after it is released, the sample history, the filtered level and the synchronizer all read 0, and no edge pulse is produced.
- R7: A change of `rate_sel` takes effect from the next sampling enable of the new rate. It does not clear the sample history.
- R8: At rate code 2'b00 with the filter enabled, a pin change held steady reaches `lvl_o` on exactly the fifth rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous capture pin |
| rate_sel | input | 2 | Sampling-rate code |
| ext_tick | input | 1 | External count-source tick, one clock wide |
| filt_en | input | 1 | 1 selects the filtered level, 0 the unfiltered level |
| lvl_o | output | 1 | Chosen level |
| rise_o | output | 1 | One-clock pulse on a 0-to-1 change of `lvl_o` |
| fall_o | output | 1 | One-clock pulse on a 1-to-0 change of `lvl_o` |

## Verification
Two functions can fall in the same cycle. One is a change of `filt_en`, which switches `lvl_o` between paths at once. The other is a filter decision on a sampling enable. Both can move `lvl_o`, and with it the edge detector, in the same cycle.
The bench provokes this by toggling `filt_en` while the pin is held at a level the filter has not yet accepted. It also toggles `filt_en` in the very cycle in which a third matching sample lands. A behavioural reference model predicts the level and both pulses every clock. A path switch must yield exactly one pulse in the right direction, or none when the two paths agree.

// File: rtl/cap_filt_pkg.sv
package cap_filt_pkg;
  typedef enum logic [1:0] {
    RATE_FULL = 2'b00,
    RATE_DIV8 = 2'b01,
    RATE_DIV32 = 2'b10,
    RATE_EXT = 2'b11
  } rate_e;

  // true when a counter whose low LOG2 bits are all ones has reached its wrap point
  function automatic logic wrap_hit(input logic [7:0] cnt, input int unsigned log2div);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(log2div)) hit = hit & cnt[i];
    end
    return hit;
  endfunction

  // agreement of a sample window: 2'b10 = all ones, 2'b01 = all zeros, 2'b00 = mixed
  function automatic logic [1:0] window_vote(input logic [7:0] win, input int unsigned len);
    logic ones, zeros;
    ones = 1'b1;
    zeros = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(len)) begin
        ones = ones & win[i];
        zeros = zeros & ~win[i];
      end
    end
    return {ones, zeros};
  endfunction
endpackage

// File: rtl/cap_filt_sync.sv
module cap_filt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_filt_rate.sv
module cap_filt_rate
  import cap_filt_pkg::*;
#(
  parameter int SLOW_LOG2 = 3,
  parameter int SLOWER_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       ext_tick,
  output logic       samp_en_o
);
  localparam int CW = SLOWER_LOG2;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cnt_w;
  rate_e         code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_w = 8'(cnt_q);
  assign code  = rate_e'(rate_sel);

  always_comb begin
    unique case (code)
      RATE_FULL:  samp_en_o = 1'b1;
      RATE_DIV8:  samp_en_o = wrap_hit(cnt_w, SLOW_LOG2);
      RATE_DIV32: samp_en_o = wrap_hit(cnt_w, SLOWER_LOG2);
      default:    samp_en_o = ext_tick;
    endcase
  end
endmodule

// File: rtl/cap_filt_vote.sv
module cap_filt_vote
  import cap_filt_pkg::*;
#(
  parameter int MATCH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic d_i,
  output logic lvl_o
);
  localparam int HW = MATCH - 1;
  logic [HW-1:0]  hist_q;
  logic [MATCH-1:0] win;
  logic [1:0]     vote;

  assign win  = {hist_q, d_i};
  assign vote = window_vote(8'(win), MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lvl_o  <= 1'b0;
    end else if (samp_en) begin
      hist_q <= win[HW-1:0];
      if (vote[1])      lvl_o <= 1'b1;
      else if (vote[0]) lvl_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_filt_edge.sv
module cap_filt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/cap_filt_top.sv
module cap_filt_top #(
  parameter int SYNC_STAGES = 2,
  parameter int MATCH = 3,
  parameter int SLOW_LOG2 = 3,
  parameter int SLOWER_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] rate_sel,
  input  logic       ext_tick,
  input  logic       filt_en,
  output logic       lvl_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic pin_sync;
  logic samp_en;
  logic filt_lvl;

  cap_filt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  cap_filt_rate #(.SLOW_LOG2(SLOW_LOG2), .SLOWER_LOG2(SLOWER_LOG2)) u_rate (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_tick(ext_tick), .samp_en_o(samp_en)
  );

  cap_filt_vote #(.MATCH(MATCH)) u_vote (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .d_i(pin_sync), .lvl_o(filt_lvl)
  );

  assign lvl_o = filt_en ? filt_lvl : pin_sync;

  cap_filt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .d_i(lvl_o), .rise_o(rise_o), .fall_o(fall_o)
  );
endmodule

// File: rtl/cap_filt_chk.sv
module cap_filt_chk (
  input logic clk,
  input logic rst_n,
  input logic filt_en,
  input logic pin_sync,
  input logic samp_en,
  input logic filt_lvl,
  input logic lvl_o,
  input logic rise_o,
  input logic fall_o
);
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o)); // R5
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R5
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R5
  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(filt_lvl)); // R2
  AST_CHANGE_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> ($past(samp_en) && $past(pin_sync) == filt_lvl)); // R2
  AST_BYPASS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |-> (lvl_o == pin_sync)); // R4
endmodule

bind cap_filt_top cap_filt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .pin_sync(pin_sync), .samp_en(samp_en),
  .filt_lvl(filt_lvl), .lvl_o(lvl_o), .rise_o(rise_o), .fall_o(fall_o)
);

// File: tb/tb_cap_filt_top.sv
module tb_cap_filt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_i = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic ext_tick = 1'b0;
  logic filt_en = 1'b0;
  logic lvl_o, rise_o, fall_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R6";

  always #2 clk = ~clk;

  cap_filt_top dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rate_sel(rate_sel),
    .ext_tick(ext_tick), .filt_en(filt_en), .lvl_o(lvl_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  // behavioural reference model
  bit pipe[$];
  bit samples[$];
  bit m_filt;
  bit m_prev;
  int m_cnt;

  function automatic bit m_sync();
    return pipe[pipe.size()-1];
  endfunction

  function automatic bit m_level();
    return filt_en ? m_filt : m_sync();
  endfunction

  task automatic model_reset();
    pipe = '{0, 0};
    samples = '{0, 0, 0};
    m_filt = 0;
    m_prev = 0;
    m_cnt = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit en;
      bit chosen_old;
      bit all1, all0;
      chosen_old = m_level();
      case (rate_sel)
        2'b00: en = 1;
        2'b01: en = (m_cnt % 8) == 7;
        2'b10: en = (m_cnt % 32) == 31;
        default: en = ext_tick;
      endcase
      if (en) begin
        samples.push_back(m_sync());
        void'(samples.pop_front());
        all1 = 1; all0 = 1;
        foreach (samples[k]) begin
          if (samples[k]) all0 = 0; else all1 = 0;
        end
        if (all1) m_filt = 1;
        if (all0) m_filt = 0;
      end
      pipe.push_front(pin_i);
      void'(pipe.pop_back());
      m_prev = chosen_old;
      m_cnt = m_cnt + 1;
    end
  end

  task automatic check(string req, bit act, bit exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit lv;
      lv = m_level();
      check(phase, lvl_o, lv, "lvl_o");
      check(phase, rise_o, lv & ~m_prev, "rise_o");
      check(phase, fall_o, ~lv & m_prev, "fall_o");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    // R6: reset state
    pin_i = 1;
    cyc(3);
    #1;
    check("R6", lvl_o, 0, "lvl_o in reset");
    check("R6", rise_o, 0, "rise_o in reset");
    check("R6", fall_o, 0, "fall_o in reset");
    pin_i = 0;
    @(negedge clk);
    rst_n = 1;
    cyc(4);

    // R1 / R4: unfiltered path latency
    phase = "R1";
    filt_en = 0;
    pin_i = 1;
    @(posedge clk); #1;
    check("R1", lvl_o, 0, "after one edge");
    @(posedge clk); #1;
    check("R1", lvl_o, 1, "after two edges");
    @(negedge clk);
    phase = "R4";
    pin_i = 0;
    cyc(4);
    for (int i = 0; i < 40; i++) begin
      pin_i = (i % 3) == 0;
      cyc(1);
    end
    pin_i = 0;
    cyc(6);

    // R2: short glitches rejected with filter on at full rate
    phase = "R2";
    filt_en = 1;
    rate_sel = 2'b00;
    cyc(4);
    pin_i = 1; cyc(2); pin_i = 0;
    cyc(6);
    check("R2", lvl_o, 0, "two-sample glitch ignored");
    pin_i = 1; cyc(1); pin_i = 0; cyc(1); pin_i = 1; cyc(2); pin_i = 0;
    cyc(6);
    check("R2", lvl_o, 0, "broken pulse ignored");

    // R8: steady change lands on the fifth edge
    phase = "R8";
    pin_i = 1;
    repeat (4) @(posedge clk);
    #1 check("R8", lvl_o, 0, "before fifth edge");
    @(posedge clk); #1;
    check("R8", lvl_o, 1, "at fifth edge");
    check("R8", rise_o, 1, "rise pulse at fifth edge");
    @(negedge clk);
    pin_i = 0;
    cyc(8);

    // R3: slower rates and external tick
    phase = "R3";
    rate_sel = 2'b01;
    for (int i = 0; i < 200; i++) begin
      pin_i = ((i / 20) % 2) == 1 || (i % 7 == 3);
      cyc(1);
    end
    rate_sel = 2'b10;
    for (int i = 0; i < 600; i++) begin
      pin_i = ((i / 110) % 2) == 1;
      cyc(1);
    end
    rate_sel = 2'b11;
    for (int i = 0; i < 300; i++) begin
      ext_tick = (i % 5) == 0 || (i % 11) == 0;
      pin_i = ((i / 37) % 2) == 0 || (i % 13 == 6);
      cyc(1);
    end
    ext_tick = 0;

    // R7: rate changes mid-history
    phase = "R7";
    for (int i = 0; i < 400; i++) begin
      if (i % 23 == 0) rate_sel = 2'((i / 23) % 4);
      ext_tick = (i % 3) == 1;
      pin_i = ((i / 17) % 2) == 1;
      cyc(1);
    end

    // R5: filter toggling on top of sampling decisions
    phase = "R5";
    rate_sel = 2'b00;
    ext_tick = 0;
    for (int i = 0; i < 600; i++) begin
      pin_i = ($urandom % 4) != 0 ? pin_i : ~pin_i;
      filt_en = ($urandom % 5) == 0 ? ~filt_en : filt_en;
      if (i % 97 == 0) rate_sel = 2'($urandom % 4);
      ext_tick = $urandom % 2;
      cyc(1);
    end

    // R6: mid-run reset clears history
    phase = "R6";
    filt_en = 1;
    rate_sel = 2'b00;
    pin_i = 1;
    cyc(8);
    rst_n = 0;
    #1;
    check("R6", lvl_o, 0, "lvl_o after reset");
    cyc(2);
    rst_n = 1;
    #1;
    check("R6", rise_o, 0, "no pulse after release");
    cyc(10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule